// File: doc/BRIEF.md
# Instruction Cache Parity Scrubber

This block walks every way of one set of an instruction cache and checks the parity carried by the stored lines. A start pulse hands it an address; the set index is taken from address bits 12:5 and held for the whole walk. For each of the four ways it issues a tag read. When data checking was requested at start, it also issues four data reads for that way, one per doubleword offset. Each read is answered by the array one cycle later on a plain synchronous read port.

Each tag answer is checked against a split parity scheme on the tag-low word and against a duplicated valid bit in the tag-high word. Each data answer is checked for predecode parity and for per-byte parity on two instruction words. Failures are collected into two sticky flags, one for the tag side and one for the data side. A done pulse marks the end of the walk, and the flags then hold until the next start.

Top module: `icache_parity_scrubber`

## Requirements
- R1: Every read address is (way << 13) | (index << 5) | (offset << 3), where the index is start address bits 12:5 latched at start. No other address bit is ever set, and tag reads always use offset 0.
- R2: Reads are issued on consecutive cycles, starting the cycle after the start is accepted. For each way from 0 to 3 there is one tag read (rd_tag_sel_o = 1), then, when data checking is on, data reads (rd_tag_sel_o = 0) for offsets 0 to 3.
- R3: With data checking off at start, exactly four tag reads are issued, for ways 0 to 3, and no data read is issued.
- R4: On a tag read, tag-low bit 10 must equal the XOR of tag-low bits 23:0 with bits 10 and 11 left out. A mismatch sets tag_err_o.
- R5: On a tag read, tag-low bit 11 must equal the XOR of tag-low bits 63:24. A mismatch sets tag_err_o.
- R6: The checks of R4 and R5 apply only when the valid bit, tag-high bit 29, is 1. A tag-low parity fault in a way whose valid bit is 0 leaves tag_err_o at 0.
- R7: Tag-high bit 27 must always equal tag-high bit 29, whatever the valid state. A mismatch sets tag_err_o.
- R8: On a data read, data-high bit 16 must equal the XOR of the predecode byte at data-high bits 15:8. A mismatch sets data_err_o.
- R9: On a data read, data-high bits 7:4 carry the per-byte XOR of instruction A and bits 3:0 that of instruction B. Byte k (bits 8k+7:8k) maps to bit k of its field. A mismatch sets data_err_o.
- R10: Both flags clear when a start is accepted. They accumulate (sticky OR) across all ways and offsets of the walk.
- R11: done_o is a one-cycle pulse, two cycles after the last read is issued. From then until the next accepted start, both flags hold steady. A start while busy_o is 1 is ignored and does not change the walk.
- R12: After reset, busy_o, done_o, rd_en_o, tag_err_o and data_err_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a walk; accepted only when idle |
| set_addr_i | input | 16 | Address whose bits 12:5 select the set |
| data_en_i | input | 1 | Also check data words during this walk |
| rd_en_o | output | 1 | Read strobe to the cache arrays |
| rd_tag_sel_o | output | 1 | 1 = tag read, 0 = data read |
| rd_addr_o | output | 16 | Read address |
| rd_tag_hi_i | input | 32 | Tag-high word, one cycle after rd_en_o |
| rd_tag_lo_i | input | 64 | Tag-low word, one cycle after rd_en_o |
| rd_data_hi_i | input | 17 | Predecode and parity bits, one cycle after rd_en_o |
| rd_inst_a_i | input | 32 | Instruction A, one cycle after rd_en_o |
| rd_inst_b_i | input | 32 | Instruction B, one cycle after rd_en_o |
| busy_o | output | 1 | Walk in progress, including drain and done cycles |
| done_o | output | 1 | One-cycle end-of-walk pulse |
| tag_err_o | output | 1 | Sticky tag or valid parity fault |
| data_err_o | output | 1 | Sticky predecode or instruction parity fault |

## Verification
The assertions assume the array answers each strobe in exactly the next cycle. They also assume start_i is a clean synchronous pulse, and that a start that arrives while busy_o is high has no effect. The bench's array model registers its response on the edge after each strobe and never answers early or late. It drives start only on falling edges, for one cycle. One run deliberately pulses start in mid-walk, so the rule that a start during a walk is ignored is exercised inside that contract and not outside it.

// File: rtl/icps_pkg.sv
package icps_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2,
    ST_DONE  = 2'd3
  } icps_state_e;

  // tag-low split parity layout
  localparam int TLO_PAR_LOW_BIT  = 10;
  localparam int TLO_PAR_HIGH_BIT = 11;
  localparam int TLO_SPLIT        = 24;
  // tag-high valid and its duplicate
  localparam int THI_VALID_BIT    = 29;
  localparam int THI_VCOPY_BIT    = 27;
  // predecode byte width
  localparam int PD_W             = 8;

endpackage

// File: rtl/icps_walker.sv
module icps_walker #(
  parameter int WAY_W = 2,
  parameter int OFF_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic             data_en,
  output logic [WAY_W-1:0] way,
  output logic [OFF_W-1:0] off,
  output logic             is_tag,
  output logic             last
);
  localparam logic [WAY_W-1:0] WAY_MAX = '1;
  localparam logic [OFF_W-1:0] OFF_MAX = '1;

  logic [WAY_W-1:0] way_q, way_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic             tag_q, tag_d;

  always_comb begin
    way_d = way_q;
    off_d = off_q;
    tag_d = tag_q;
    if (clr) begin
      way_d = '0;
      off_d = '0;
      tag_d = 1'b1;
    end else if (adv) begin
      if (tag_q) begin
        if (data_en) begin
          tag_d = 1'b0;
          off_d = '0;
        end else begin
          way_d = way_q + 1'b1;
        end
      end else if (off_q == OFF_MAX) begin
        tag_d = 1'b1;
        off_d = '0;
        way_d = way_q + 1'b1;
      end else begin
        off_d = off_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      way_q <= '0;
      off_q <= '0;
      tag_q <= 1'b1;
    end else if (clr || adv) begin
      way_q <= way_d;
      off_q <= off_d;
      tag_q <= tag_d;
    end
  end

  assign way    = way_q;
  assign off    = off_q;
  assign is_tag = tag_q;
  assign last   = (way_q == WAY_MAX) && (tag_q ? !data_en : (off_q == OFF_MAX));

endmodule

// File: rtl/icps_tag_chk.sv
module icps_tag_chk #(
  parameter int TLO_W = 64,
  parameter int THI_W = 32
) (
  input  logic [THI_W-1:0] tag_hi,
  input  logic [TLO_W-1:0] tag_lo,
  output logic             err
);
  import icps_pkg::*;

  localparam logic [TLO_SPLIT-1:0] LOW_MASK =
    ~((TLO_SPLIT'(1) << TLO_PAR_LOW_BIT) | (TLO_SPLIT'(1) << TLO_PAR_HIGH_BIT));

  logic par_low, par_high, vld, low_bad, high_bad, copy_bad;
  logic unused_thi;

  always_comb begin
    par_low  = ^(tag_lo[TLO_SPLIT-1:0] & LOW_MASK);
    par_high = ^tag_lo[TLO_W-1:TLO_SPLIT];
    vld      = tag_hi[THI_VALID_BIT];
    low_bad  = par_low  ^ tag_lo[TLO_PAR_LOW_BIT];
    high_bad = par_high ^ tag_lo[TLO_PAR_HIGH_BIT];
    copy_bad = vld ^ tag_hi[THI_VCOPY_BIT];
    err      = (vld & (low_bad | high_bad)) | copy_bad;
  end

  assign unused_thi = ^tag_hi;

endmodule

// File: rtl/icps_data_chk.sv
module icps_data_chk #(
  parameter int INST_W = 32
) (
  input  logic [icps_pkg::PD_W + 2*(INST_W/8):0] data_hi,
  input  logic [INST_W-1:0]                       inst_a,
  input  logic [INST_W-1:0]                       inst_b,
  output logic                                    err
);
  import icps_pkg::*;

  localparam int NB      = INST_W / 8;
  localparam int B_LSB   = 0;
  localparam int A_LSB   = NB;
  localparam int PD_LSB  = 2 * NB;
  localparam int PDP_BIT = PD_LSB + PD_W;

  logic [NB-1:0] calc_a, calc_b;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign calc_a[b] = ^inst_a[8*b +: 8];
    assign calc_b[b] = ^inst_b[8*b +: 8];
  end

  logic pd_bad, a_bad, b_bad;

  always_comb begin
    pd_bad = (^data_hi[PD_LSB +: PD_W]) ^ data_hi[PDP_BIT];
    a_bad  = calc_a != data_hi[A_LSB +: NB];
    b_bad  = calc_b != data_hi[B_LSB +: NB];
    err    = pd_bad | a_bad | b_bad;
  end

endmodule

// File: rtl/icache_parity_scrubber.sv
module icache_parity_scrubber #(
  parameter int ADDR_W  = 16,
  parameter int IDX_LSB = 5,
  parameter int IDX_W   = 8,
  parameter int OFF_LSB = 3,
  parameter int OFF_W   = 2,
  parameter int WAY_LSB = 13,
  parameter int WAY_W   = 2,
  parameter int INST_W  = 32,
  parameter int TLO_W   = 64,
  parameter int THI_W   = 32
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    start_i,
  input  logic [ADDR_W-1:0]                       set_addr_i,
  input  logic                                    data_en_i,
  output logic                                    rd_en_o,
  output logic                                    rd_tag_sel_o,
  output logic [ADDR_W-1:0]                       rd_addr_o,
  input  logic [THI_W-1:0]                        rd_tag_hi_i,
  input  logic [TLO_W-1:0]                        rd_tag_lo_i,
  input  logic [icps_pkg::PD_W + 2*(INST_W/8):0]  rd_data_hi_i,
  input  logic [INST_W-1:0]                       rd_inst_a_i,
  input  logic [INST_W-1:0]                       rd_inst_b_i,
  output logic                                    busy_o,
  output logic                                    done_o,
  output logic                                    tag_err_o,
  output logic                                    data_err_o
);
  import icps_pkg::*;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  icps_state_e      state_q, state_d;
  logic [IDX_W-1:0] idx_q;
  logic             den_q;
  logic             resp_vld_q, resp_tag_q;
  logic             terr_q, terr_d, derr_q, derr_d;
  logic             accept, issue;

  logic [WAY_W-1:0] way;
  logic [OFF_W-1:0] off;
  logic             is_tag, last;
  logic             tag_bad, data_bad;
  logic             unused_addr;

  assign accept = start_i && (state_q == ST_IDLE);
  assign issue  = (state_q == ST_ISSUE);

  icps_walker #(.WAY_W(WAY_W), .OFF_W(OFF_W)) u_walk (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clr     (accept),
    .adv     (issue),
    .data_en (den_q),
    .way     (way),
    .off     (off),
    .is_tag  (is_tag),
    .last    (last)
  );

  icps_tag_chk #(.TLO_W(TLO_W), .THI_W(THI_W)) u_tag (
    .tag_hi (rd_tag_hi_i),
    .tag_lo (rd_tag_lo_i),
    .err    (tag_bad)
  );

  icps_data_chk #(.INST_W(INST_W)) u_data (
    .data_hi (rd_data_hi_i),
    .inst_a  (rd_inst_a_i),
    .inst_b  (rd_inst_b_i),
    .err     (data_bad)
  );

  // next state
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_ISSUE;
      ST_ISSUE: if (last)    state_d = ST_DRAIN;
      ST_DRAIN:              state_d = ST_DONE;
      ST_DONE:               state_d = ST_IDLE;
      default:               state_d = ST_IDLE;
    endcase
  end

  // flag accumulation
  always_comb begin
    terr_d = terr_q;
    derr_d = derr_q;
    if (accept) begin
      terr_d = 1'b0;
      derr_d = 1'b0;
    end else if (resp_vld_q) begin
      if (resp_tag_q) terr_d = terr_q | tag_bad;
      else            derr_d = derr_q | data_bad;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q    <= ST_IDLE;
      resp_vld_q <= 1'b0;
      resp_tag_q <= 1'b0;
      terr_q     <= 1'b0;
      derr_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      resp_vld_q <= issue;
      resp_tag_q <= is_tag;
      terr_q     <= terr_d;
      derr_q     <= derr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      idx_q <= '0;
      den_q <= 1'b0;
    end else if (accept) begin
      idx_q <= set_addr_i[IDX_LSB +: IDX_W];
      den_q <= data_en_i;
    end
  end

  always_comb begin
    rd_addr_o = (ADDR_W'(way) << WAY_LSB) | (ADDR_W'(idx_q) << IDX_LSB);
    if (!is_tag) rd_addr_o = rd_addr_o | (ADDR_W'(off) << OFF_LSB);
  end

  assign rd_en_o      = issue;
  assign rd_tag_sel_o = is_tag;
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = (state_q == ST_DONE);
  assign tag_err_o    = terr_q;
  assign data_err_o   = derr_q;
  assign unused_addr  = ^set_addr_i;

endmodule

// File: rtl/icps_chk.sv
module icps_chk #(
  parameter int ADDR_W  = 16,
  parameter int IDX_LSB = 5,
  parameter int IDX_W   = 8,
  parameter int OFF_LSB = 3,
  parameter int OFF_W   = 2,
  parameter int WAY_LSB = 13,
  parameter int WAY_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              rd_en_o,
  input logic              rd_tag_sel_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              tag_err_o,
  input logic              data_err_o
);
  localparam logic [ADDR_W-1:0] FIELDS =
    ((ADDR_W'(1) << WAY_W) - 1'b1) << WAY_LSB |
    ((ADDR_W'(1) << IDX_W) - 1'b1) << IDX_LSB |
    ((ADDR_W'(1) << OFF_W) - 1'b1) << OFF_LSB;

  // R1: nothing outside the way, index and offset fields
  a_r1_spare_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |-> ((rd_addr_o & ~FIELDS) == '0));

  // R1: tag reads use offset zero
  a_r1_tag_offset_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_o && rd_tag_sel_o) |-> (rd_addr_o[OFF_LSB +: OFF_W] == '0));

  // R1: the index does not move during a walk
  a_r1_index_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_o && $past(rd_en_o)) |-> (rd_addr_o[IDX_LSB +: IDX_W] == $past(rd_addr_o[IDX_LSB +: IDX_W])));

  // R2: reads only inside a walk
  a_r2_read_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |-> busy_o);

  // R2: the first read of a walk is the way-0 tag
  a_r2_first_is_tag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_en_o) |-> (rd_tag_sel_o && rd_addr_o[WAY_LSB +: WAY_W] == '0));

  // R10: accepted start clears both flags
  a_r10_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (!tag_err_o && !data_err_o));

  // R11: single-cycle done, no read alongside
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r11_done_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !rd_en_o);

  // R11: flags hold while idle and no start
  a_r11_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(tag_err_o) && $stable(data_err_o)));

endmodule

bind icache_parity_scrubber icps_chk #(
  .ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W), .OFF_LSB(OFF_LSB),
  .OFF_W(OFF_W), .WAY_LSB(WAY_LSB), .WAY_W(WAY_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_en_o(rd_en_o),
  .rd_tag_sel_o(rd_tag_sel_o), .rd_addr_o(rd_addr_o), .busy_o(busy_o),
  .done_o(done_o), .tag_err_o(tag_err_o), .data_err_o(data_err_o)
);

// File: tb/sim_icache_parity_scrubber.sv
module sim_icache_parity_scrubber;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic        start_i = 1'b0;
  logic [15:0] set_addr_i = '0;
  logic        data_en_i = 1'b0;
  logic        rd_en_o, rd_tag_sel_o, busy_o, done_o, tag_err_o, data_err_o;
  logic [15:0] rd_addr_o;
  logic [31:0] rd_tag_hi_i = '0;
  logic [63:0] rd_tag_lo_i = '0;
  logic [16:0] rd_data_hi_i = '0;
  logic [31:0] rd_inst_a_i = '0, rd_inst_b_i = '0;

  icache_parity_scrubber u0 (.*);

  int n_cmp = 0, n_bad = 0, n_done = 0, run_reads = 0, cyc = 0;
  logic [16:0] exp_rd[$];
  logic [1:0]  exp_flag[$];
  int          exp_cnt[$];

  // fault injection: two slots; kinds 1 low tag par, 2 high tag par,
  // 3 valid copy, 4 predecode, 5 inst A, 6 inst B, 7 consistent MSB flip
  int k_s[2], w_s[2], o_s[2];
  logic [3:0] inval;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mix(input logic [15:0] a, input logic [63:0] s);
    logic [63:0] h;
    h = (64'(a) + s) * 64'h9E37_79B9_7F4A_7C15;
    h = h ^ (h >> 29);
    return h * 64'hBF58_476D_1CE4_E5B9;
  endfunction

  function automatic logic [3:0] bpar(input logic [31:0] x);
    return {^x[31:24], ^x[23:16], ^x[15:8], ^x[7:0]};
  endfunction

  // array model: answers one cycle after each strobe
  always @(posedge clk) begin
    if (rd_en_o) begin : resp
      logic [63:0] h, g, tlo;
      logic [31:0] thi, ia, ib;
      logic [16:0] dhi;
      logic [7:0]  pd;
      int w, o;
      w = int'(rd_addr_o[14:13]);
      o = int'(rd_addr_o[4:3]);
      h = mix(rd_addr_o, 64'h1234_5678_9ABC_DEF1);
      g = mix(rd_addr_o, 64'h0F0E_0D0C_0B0A_0908);
      tlo = h;
      tlo[10] = ^(h[23:0] & 24'hFFF3FF);
      tlo[11] = ^h[63:24];
      thi = g[31:0];
      thi[29] = !inval[w];
      thi[27] = !inval[w];
      ia = h[31:0]; ib = h[63:32]; pd = g[47:40];
      dhi = {^pd, pd, bpar(ia), bpar(ib)};
      for (int s = 0; s < 2; s++) begin
        if (w_s[s] == w) begin
          if (rd_tag_sel_o) begin
            if (k_s[s] == 1) tlo[10] = ~tlo[10];
            if (k_s[s] == 2) tlo[40] = ~tlo[40];
            if (k_s[s] == 3) thi[27] = ~thi[27];
          end else if (o_s[s] == o) begin
            if (k_s[s] == 4) dhi[16] = ~dhi[16];
            if (k_s[s] == 5) ia[5] = ~ia[5];
            if (k_s[s] == 6) ib[20] = ~ib[20];
            if (k_s[s] == 7) begin ia[31] = ~ia[31]; dhi[7] = ~dhi[7]; end
          end
        end
      end
      rd_tag_lo_i  <= tlo;
      rd_tag_hi_i  <= thi;
      rd_data_hi_i <= dhi;
      rd_inst_a_i  <= ia;
      rd_inst_b_i  <= ib;
    end
  end

  // monitor: pops expected reads and end-of-walk results
  always @(negedge clk) begin
    cyc++;
    if (rst_n && rd_en_o) begin
      run_reads++;
      if (exp_rd.size() == 0) chk(1'b0, "R2 unexpected read", {rd_tag_sel_o, rd_addr_o}, 0);
      else begin : pop_rd
        logic [16:0] e;
        e = exp_rd.pop_front();
        chk({rd_tag_sel_o, rd_addr_o} == e, "R1/R2 read sequence", {rd_tag_sel_o, rd_addr_o}, e);
      end
    end
    if (rst_n && done_o) begin
      n_done++;
      if (exp_flag.size() == 0) chk(1'b0, "R11 unexpected done", 1, 0);
      else begin : pop_res
        logic [1:0] f;
        int c;
        f = exp_flag.pop_front();
        c = exp_cnt.pop_front();
        chk({tag_err_o, data_err_o} == f, "R4-R10 flags at done", {tag_err_o, data_err_o}, f);
        chk(run_reads == c, "R3 read count", run_reads, c);
      end
      run_reads = 0;
    end
  end

  function automatic bit is_tag_kind(input int k, input int w);
    return ((k == 1 || k == 2) && !inval[w]) || k == 3;
  endfunction

  task automatic run_case(input logic [15:0] a, input bit den, input logic [3:0] inv,
                          input int k0, input int w0, input int o0,
                          input int k1, input int w1, input int o1,
                          input bit poke, input string req);
    logic [1:0] ef;
    int cnt, start_done, t;
    logic [15:0] base;
    k_s[0] = k0; w_s[0] = w0; o_s[0] = o0;
    k_s[1] = k1; w_s[1] = w1; o_s[1] = o1;
    inval = inv;
    base = {3'b000, a[12:5], 5'b00000};
    cnt = 0;
    for (int w = 0; w < 4; w++) begin
      exp_rd.push_back({1'b1, base | 16'(w << 13)});
      cnt++;
      if (den) for (int o = 0; o < 4; o++) begin
        exp_rd.push_back({1'b0, base | 16'(w << 13) | 16'(o << 3)});
        cnt++;
      end
    end
    ef = 2'b00;
    for (int s = 0; s < 2; s++) begin
      if (is_tag_kind(k_s[s], w_s[s])) ef[1] = 1'b1;
      if (den && k_s[s] >= 4 && k_s[s] <= 6) ef[0] = 1'b1;
    end
    exp_flag.push_back(ef);
    exp_cnt.push_back(cnt);
    start_done = n_done;
    @(negedge clk);
    set_addr_i = a; data_en_i = den; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      repeat (2) @(negedge clk);
      set_addr_i = ~a; data_en_i = !den; start_i = 1'b1;  // R11: ignored while busy
      @(negedge clk);
      start_i = 1'b0;
    end
    t = 0;
    while (n_done == start_done && t < 200) begin @(negedge clk); t++; end
    if (t >= 200) chk(1'b0, {req, " watchdog"}, 0, 1);
    repeat (3) @(negedge clk);
    chk({tag_err_o, data_err_o} == ef, {"R11 flags hold ", req}, {tag_err_o, data_err_o}, ef);
    chk(!busy_o && !done_o, {"R11 idle after ", req}, {busy_o, done_o}, 0);
  endtask

  initial begin : watchdog
    wait (cyc > 100000);
    chk(1'b0, "watchdog", cyc, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    k_s = '{0, 0}; w_s = '{0, 0}; o_s = '{0, 0}; inval = '0;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk({busy_o, done_o, rd_en_o, tag_err_o, data_err_o} == 5'b0, "R12 reset outputs",
        {busy_o, done_o, rd_en_o, tag_err_o, data_err_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({busy_o, done_o, rd_en_o, tag_err_o, data_err_o} == 5'b0, "R12 after release",
        {busy_o, done_o, rd_en_o, tag_err_o, data_err_o}, 0);

    run_case(16'hFFFF, 1, 4'h0, 0,0,0, 0,0,0, 0, "R2 clean full walk");
    run_case(16'h0A40, 0, 4'h0, 0,0,0, 0,0,0, 0, "R3 tags only");
    run_case(16'h1234, 0, 4'h0, 1,2,0, 0,0,0, 0, "R4 low tag parity");
    run_case(16'h0020, 1, 4'h0, 0,0,0, 0,0,0, 0, "R10 clears after error");
    run_case(16'h1FE0, 0, 4'h0, 2,3,0, 0,0,0, 0, "R5 high tag parity");
    run_case(16'h0100, 1, 4'h2, 1,1,0, 2,1,0, 0, "R6 invalid way not checked");
    run_case(16'h0300, 0, 4'h1, 3,0,0, 0,0,0, 0, "R7 valid copy on invalid way");
    run_case(16'h0400, 1, 4'h0, 3,2,0, 0,0,0, 0, "R7 valid copy on valid way");
    run_case(16'h0560, 1, 4'h0, 4,1,2, 0,0,0, 0, "R8 predecode parity");
    run_case(16'h0680, 1, 4'h0, 5,3,3, 0,0,0, 0, "R9 inst A parity");
    run_case(16'h07A0, 1, 4'h0, 6,0,0, 0,0,0, 0, "R9 inst B parity");
    run_case(16'h08C0, 1, 4'h0, 7,2,1, 0,0,0, 0, "R9 MSB byte to MSB bit");
    run_case(16'h09E0, 0, 4'h0, 4,1,2, 6,2,3, 0, "R3 data faults unseen when off");
    run_case(16'h0BE0, 1, 4'h0, 1,0,0, 5,3,1, 0, "R10 both flags accumulate");
    run_case(16'h0C20, 1, 4'h0, 2,1,0, 0,0,0, 1, "R11 start ignored while busy");
    run_case(16'h0D40, 1, 4'h0, 0,0,0, 0,0,0, 0, "R10 clean after errors");

    chk(exp_rd.size() == 0, "R2 all reads seen", exp_rd.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule